// File: doc/BRIEF.md
# Shift-Register Upset Test Sequencer

This block runs a static upset test on a long chain of flip-flops. On a start command it fills the chain through its serial input with one of four data patterns. It then stops clocking the chain and reports the level at which the chain clock must be parked while the chain is exposed. When the host issues a release command, it shifts the whole chain out again. While the bits come out, it regenerates the same pattern one bit at a time and counts every bit that differs.

The host picks one of three base patterns (all zeros, all ones, or alternating bits) and one of two parked clock levels, which gives six test configurations. A fourth pattern code gives the alternating pattern with the opposite phase. The host reads back the error count and the stream index of the first wrong bit. The chain length is a parameter (default 4096). The flip-flops and their clock buffering are outside the block: the block only drives the chain's serial input, clock enable and park level, and it samples the chain's serial output.

Top module: `sr_upset_seq`

## Requirements
- R1: After reset the chain clock enable is low, done is low, the error count is 0 and the first-error valid flag is low.
- R2: An accepted start holds the chain clock enable high for exactly CHAIN_LEN cycles (the load), after which the enable drops and the block holds.
- R3: During the load, stream bit k (k = 0 first) on the serial input is 0 for pattern code 2'b00, 1 for 2'b01, k[0] for 2'b10 and the inverse of k[0] for 2'b11. Stream bit 0 ends up at the serial-output end of the chain.
- R4: The hold keeps the chain clock enable low until a release_hold pulse. A start during the hold and a release_hold outside the hold have no effect.
- R5: chain_clk_park equals the cfg_park_level captured at the accepted start and stays unchanged until the run ends. Changes on cfg_pattern or cfg_park_level after the start do not alter the run.
- R6: After release the enable is high for exactly CHAIN_LEN cycles (the unload). In unload cycle j, chain_so is compared with the R3 stream bit j.
- R7: err_count equals the number of mismatching bits in the last run and is cleared by an accepted start.
- R8: first_err_valid goes high on the first mismatch of a run, and first_err_idx then holds the lowest mismatching stream index. Both are cleared by an accepted start.
- R9: done goes high after the unload and stays high until the next start, which begins a new run from the done state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in idle or done) |
| release_hold | input | 1 | End the hold and begin the unload |
| cfg_pattern | input | 2 | Pattern code, see R3 |
| cfg_park_level | input | 1 | Clock level to hold during exposure |
| chain_si | output | 1 | Serial data into the chain |
| chain_so | input | 1 | Serial data out of the chain |
| chain_clk_en | output | 1 | Chain shifts on each clock while high |
| chain_clk_park | output | 1 | Parked chain clock level for this run |
| done | output | 1 | Run complete |
| err_count | output | CNT_W | Mismatching bits in the run |
| first_err_idx | output | IDX_W | Stream index of the first mismatch |
| first_err_valid | output | 1 | first_err_idx is meaningful |

## Verification
A wrong index or state in the sequencer shows up at once as a load or unload that is longer or shorter than the chain. The enable pulse then has the wrong width in the same run, and the error count for a clean chain becomes nonzero. A pattern phase that is off by one shows on the very first unloaded bit of an alternating run, so the count is wrong by the time done rises. A flaw in the compare or the first-index capture is seen only after done. The bench exposes these by flipping known chain bits during the hold and predicting the exact count and first index.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_HOLD, S_UNLOAD, S_DONE
  } sru_state_e;

  typedef enum logic [1:0] {
    PAT_ZERO = 2'b00,
    PAT_ONE  = 2'b01,
    PAT_ALT  = 2'b10,
    PAT_ALTN = 2'b11
  } sru_pat_e;

  // Stream bit for position whose LSB is idx_lsb
  function automatic logic sru_pat_bit(input logic [1:0] code, input logic idx_lsb);
    case (code)
      PAT_ZERO: return 1'b0;
      PAT_ONE:  return 1'b1;
      PAT_ALT:  return idx_lsb;
      default:  return ~idx_lsb;
    endcase
  endfunction
endpackage

// File: rtl/sru_patgen.sv
module sru_patgen
  import sru_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic [1:0]       code,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  always_comb bit_o = sru_pat_bit(code, idx[0]);
endmodule

// File: rtl/sru_ctrl.sv
module sru_ctrl
  import sru_pkg::*;
#(
  parameter int CHAIN_LEN = 4096,
  localparam int IDX_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             release_hold,
  input  logic [1:0]       cfg_pattern,
  input  logic             cfg_park_level,
  output sru_state_e       state,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       pat_q,
  output logic             park_q,
  output logic             accept_start,
  output logic             in_load,
  output logic             in_hold,
  output logic             in_unload
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHAIN_LEN - 1);

  logic at_last;

  always_comb begin
    at_last      = (idx == LAST);
    accept_start = start && (state == S_IDLE || state == S_DONE);
    in_load      = (state == S_LOAD);
    in_hold      = (state == S_HOLD);
    in_unload    = (state == S_UNLOAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      pat_q  <= 2'b00;
      park_q <= 1'b0;
    end else begin
      if (accept_start) begin
        state  <= S_LOAD;
        idx    <= '0;
        pat_q  <= cfg_pattern;
        park_q <= cfg_park_level;
      end else begin
        case (state)
          S_LOAD: begin
            idx <= at_last ? '0 : idx + 1'b1;
            if (at_last) state <= S_HOLD;
          end
          S_HOLD: if (release_hold) state <= S_UNLOAD;
          S_UNLOAD: begin
            idx <= at_last ? '0 : idx + 1'b1;
            if (at_last) state <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_hold) |-> ($past(idx) == LAST && $past(in_load)));

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !release_hold) |=> in_hold);

  // R5
  park_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && state != S_DONE && $past(state != S_IDLE && state != S_DONE))
      |-> ($stable(park_q) && $stable(pat_q)));
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int CHAIN_LEN = 4096,
  localparam int IDX_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int CNT_W = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cmp_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             got_bit,
  input  logic             exp_bit,
  output logic [CNT_W-1:0] err_count,
  output logic [IDX_W-1:0] first_idx,
  output logic             first_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic mismatch;
  always_comb mismatch = cmp_en && (got_bit != exp_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count   <= '0;
      first_idx   <= '0;
      first_valid <= 1'b0;
    end else if (clr) begin
      err_count   <= '0;
      first_idx   <= '0;
      first_valid <= 1'b0;
    end else if (mismatch) begin
      if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
      if (!first_valid) begin
        first_idx   <= idx;
        first_valid <= 1'b1;
      end
    end
  end

  // R7
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_count >= $past(err_count)));

  // R8
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_valid) |-> (err_count == CNT_W'(1)));
endmodule

// File: rtl/sr_upset_seq.sv
module sr_upset_seq
  import sru_pkg::*;
#(
  parameter int CHAIN_LEN = 4096,
  localparam int IDX_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int CNT_W = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             release_hold,
  input  logic [1:0]       cfg_pattern,
  input  logic             cfg_park_level,
  output logic             chain_si,
  input  logic             chain_so,
  output logic             chain_clk_en,
  output logic             chain_clk_park,
  output logic             done,
  output logic [CNT_W-1:0] err_count,
  output logic [IDX_W-1:0] first_err_idx,
  output logic             first_err_valid
);
  sru_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [1:0]       pat_q;
  logic             park_q, accept_start, in_load, in_hold, in_unload;
  logic             pat_bit;

  sru_ctrl #(.CHAIN_LEN(CHAIN_LEN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .release_hold(release_hold),
    .cfg_pattern(cfg_pattern), .cfg_park_level(cfg_park_level),
    .state(state), .idx(idx), .pat_q(pat_q), .park_q(park_q),
    .accept_start(accept_start), .in_load(in_load), .in_hold(in_hold),
    .in_unload(in_unload)
  );

  sru_patgen #(.IDX_W(IDX_W)) patgen_i (
    .code(pat_q), .idx(idx), .bit_o(pat_bit)
  );

  sru_checker #(.CHAIN_LEN(CHAIN_LEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(accept_start), .cmp_en(in_unload),
    .idx(idx), .got_bit(chain_so), .exp_bit(pat_bit),
    .err_count(err_count), .first_idx(first_err_idx),
    .first_valid(first_err_valid)
  );

  always_comb begin
    chain_si       = in_load & pat_bit;
    chain_clk_en   = in_load | in_unload;
    chain_clk_park = park_q;
    done           = (state == S_DONE);
  end

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chain_clk_en);

  // R4
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && $past(in_hold)) |-> !chain_clk_en);
endmodule

// File: tb/sr_upset_seq_tb_top.sv
module sr_upset_seq_tb_top;
  localparam int LEN   = 16;
  localparam int IDX_W = $clog2(LEN);
  localparam int CNT_W = $clog2(LEN + 1);

  logic clk = 0, rst_n = 0, start = 0, release_hold = 0;
  logic [1:0] cfg_pattern = 0;
  logic cfg_park_level = 0;
  logic chain_si, chain_so, chain_clk_en, chain_clk_park, done, first_err_valid;
  logic [CNT_W-1:0] err_count;
  logic [IDX_W-1:0] first_err_idx;

  logic [LEN-1:0] ch = '0, inj_mask = '0;
  logic inj = 0;
  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (inj) ch <= ch ^ inj_mask;
    else if (chain_clk_en) ch <= {ch[LEN-2:0], chain_si};
  end
  assign chain_so = ch[LEN-1];

  sr_upset_seq #(.CHAIN_LEN(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .release_hold(release_hold),
    .cfg_pattern(cfg_pattern), .cfg_park_level(cfg_park_level),
    .chain_si(chain_si), .chain_so(chain_so), .chain_clk_en(chain_clk_en),
    .chain_clk_park(chain_clk_park), .done(done), .err_count(err_count),
    .first_err_idx(first_err_idx), .first_err_valid(first_err_valid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int code, input int k);
    case (code)
      0: return 1'b0;
      1: return 1'b1;
      2: return 1'(k % 2);
      default: return 1'(1 - k % 2);
    endcase
  endfunction

  task automatic count_en(output int n);
    n = 0;
    while (chain_clk_en && n < 4 * LEN) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run(input int code, input int park, input logic [LEN-1:0] mask);
    int n, nerr, first;
    logic [LEN-1:0] img, snap;
    cfg_pattern = 2'(code); cfg_park_level = 1'(park);
    start = 1; @(negedge clk); start = 0;
    count_en(n);
    check("R2 load length", n, LEN);
    for (int j = 0; j < LEN; j++) img[LEN-1-j] = exp_bit(code, j);
    check("R3 chain image", ch, img);
    check("R5 park level", chain_clk_park, park);
    // disturb inputs during hold
    cfg_pattern = 2'(code + 1); cfg_park_level = 1'(~park);
    start = 1; @(negedge clk); start = 0;
    snap = ch;
    repeat (4) @(negedge clk);
    check("R4 enable low in hold", chain_clk_en, 0);
    check("R4 chain still in hold", ch, snap);
    check("R5 park kept", chain_clk_park, park);
    inj_mask = mask; inj = 1; @(negedge clk); inj = 0;
    release_hold = 1; @(negedge clk); release_hold = 0;
    count_en(n);
    check("R6 unload length", n, LEN);
    check("R9 done", done, 1);
    nerr = 0; first = -1;
    for (int j = 0; j < LEN; j++)
      if (mask[LEN-1-j]) begin
        nerr++;
        if (first < 0) first = j;
      end
    check("R7 error count", err_count, nerr);
    check("R8 first valid", first_err_valid, first >= 0);
    if (first >= 0) check("R8 first index", first_err_idx, first);
    repeat (2) @(negedge clk);
    check("R9 done holds", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 enable", chain_clk_en, 0);
    check("R1 done", done, 0);
    check("R1 count", err_count, 0);
    check("R1 first valid", first_err_valid, 0);
    release_hold = 1; @(negedge clk); release_hold = 0;
    @(negedge clk);
    check("R4 release in idle ignored", chain_clk_en, 0);
    for (int code = 0; code < 4; code++)
      for (int park = 0; park < 2; park++)
        for (int m = 0; m < 4; m++) begin
          logic [LEN-1:0] mask;
          case (m)
            0: mask = '0;
            1: mask = LEN'(1) << ((code * 2 + park * 5 + 3) % LEN);
            2: mask = '1;
            default: mask = LEN'(16'h0A50 ^ (code << 1));
          endcase
          run(code, park, mask);
        end
    // R7 a clean run after a faulty one clears the count
    run(2, 1, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule